// File: doc/BRIEF.md
# Status Register with Bank Pointer

This block holds the 16-bit status word of a small processor. The upper byte is the pointer into an external banked register file. The lower byte holds the condition flags. Three sources can change the word. A pair of single-word control operations moves the bank pointer up or down by one and leaves every flag as it was, so a flag set by a called routine survives the bank switch on return. A general ALU write replaces the whole word; this happens when an add or subtract names the status register as its destination. Ordinary ALU operations rewrite only the flag field.

The block drives a bank-select output for the register file. After a bank step it also tells the instruction sequencer to go straight back to fetch, with the program counter as the next memory address. A bank step therefore takes two cycles in total: the issue cycle and the fetch-return cycle.

Top module: `status_bank_reg`

## Requirements
- R1: While reset is held and after it is released, `sr_out`, `bank_sel`, `fetch_return` and `fetch_addr` are all zero. This selects bank 0 with every flag clear.
- R2: `bank_inc` adds 1 to `sr_out[15:8]` at the next clock edge, and bank 0xFF wraps to 0x00.
- R3: `bank_dec` subtracts 1 from `sr_out[15:8]` at the next clock edge, and bank 0x00 wraps to 0xFF.
- R4: A bank step leaves `sr_out[7:0]` unchanged, including carry and overflow. No flag is raised on wraparound.
- R5: In the cycle after a bank step is taken, `fetch_return` is 1 and `fetch_addr` equals the `pc_in` value from the step cycle. In every other cycle `fetch_return` is 0 and `fetch_addr` holds its value.
- R6: `sr_wr_en` loads `sr_out[15:8]` from `sr_wr_data[15:8]` and `sr_out[4:0]` from `sr_wr_data[4:0]` at the next edge. For example, a write of 0x0105 gives bank 1 with flags 0x05.
- R7: `flag_upd_en` replaces `sr_out[4:0]` with `flag_upd_in[4:0]` and leaves the bank unchanged. The flag positions are: bit 0 all-ones result, bit 1 carry, bit 2 zero, bit 3 negative, bit 4 overflow.
- R8: The unused flag positions `sr_out[7:5]` always read zero, whatever is written.
- R9: The update sources have a fixed priority. A general write beats a bank step, and a bank step beats a flag update; the losing request has no effect. When `bank_inc` and `bank_dec` are both high, the increment is taken.
- R10: `bank_sel` is a registered copy of the bank byte and equals `sr_out[15:8]` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bank_inc | input | 1 | Step the bank pointer up by one |
| bank_dec | input | 1 | Step the bank pointer down by one |
| sr_wr_en | input | 1 | General write of the whole status word from the ALU |
| sr_wr_data | input | 16 | ALU result written when `sr_wr_en` is high |
| flag_upd_en | input | 1 | Flag update from an ordinary ALU operation |
| flag_upd_in | input | 8 | New flag byte; only bits 4:0 are kept |
| pc_in | input | 16 | Program counter, captured as the fetch address on a bank step |
| sr_out | output | 16 | Current status word |
| bank_sel | output | 8 | Bank select to the register file |
| fetch_return | output | 1 | One-cycle pulse telling the sequencer to return to fetch |
| fetch_addr | output | 16 | Next memory address after a bank step |

## Verification
The two functions that can fall in the same cycle are a bank step and an ALU flag update. A general write can also land on top of either of them. The bench provokes these collisions on purpose by raising a step together with a flag update that carries a different flag pattern, a write together with a step, and both step directions together. It also provokes them at random over a long mixed sequence. Each collision is judged against a behavioural model that applies the stated priority. The expected word shows the step moving the bank and the old flags kept, or the write value with no fetch-return pulse.

// File: rtl/sr_pkg.sv
package sr_pkg;

  // Positions of the live condition flags in the low byte.
  localparam int FLG_X = 0;  // all-ones result
  localparam int FLG_C = 1;  // carry
  localparam int FLG_Z = 2;  // zero
  localparam int FLG_N = 3;  // negative
  localparam int FLG_V = 4;  // overflow

  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_WRITE = 2'd1,
    UPD_STEP  = 2'd2,
    UPD_FLAGS = 2'd3
  } upd_kind_e;

endpackage

// File: rtl/sr_rst_sync.sv
module sr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/sr_bank_step.sv
module sr_bank_step #(
  parameter int BANK_W = 8
) (
  input  logic [BANK_W-1:0] bank_q,
  input  logic              inc,
  input  logic              dec,
  output logic              step_req,
  output logic [BANK_W-1:0] bank_nxt
);

  localparam logic [BANK_W-1:0] ONE = BANK_W'(1);

  // Modulo arithmetic on the bank field; increment wins when both requested.
  always_comb begin
    step_req = inc | dec;
    if (inc) begin
      bank_nxt = bank_q + ONE;
    end else if (dec) begin
      bank_nxt = bank_q - ONE;
    end else begin
      bank_nxt = bank_q;
    end
  end

endmodule

// File: rtl/sr_next_sel.sv
module sr_next_sel
  import sr_pkg::*;
#(
  parameter int BANK_W     = 8,
  parameter int FLAG_W     = 8,
  parameter int LIVE_FLAGS = 5,
  localparam int SR_W      = BANK_W + FLAG_W
) (
  input  logic [SR_W-1:0]   sr_q,
  input  logic              wr_en,
  input  logic [SR_W-1:0]   wr_data,
  input  logic              step_req,
  input  logic [BANK_W-1:0] bank_step_nxt,
  input  logic              flag_en,
  input  logic [FLAG_W-1:0] flag_in,
  output logic [SR_W-1:0]   sr_nxt,
  output logic              load_en,
  output logic              step_taken
);

  localparam logic [FLAG_W-1:0] LIVE_MASK =
    {{(FLAG_W-LIVE_FLAGS){1'b0}}, {LIVE_FLAGS{1'b1}}};

  upd_kind_e kind;

  // Priority: general write, then bank step, then flag update.
  always_comb begin
    if (wr_en) begin
      kind = UPD_WRITE;
    end else if (step_req) begin
      kind = UPD_STEP;
    end else if (flag_en) begin
      kind = UPD_FLAGS;
    end else begin
      kind = UPD_NONE;
    end
  end

  always_comb begin
    sr_nxt = sr_q;
    unique case (kind)
      UPD_WRITE: sr_nxt = {wr_data[SR_W-1:FLAG_W], wr_data[FLAG_W-1:0] & LIVE_MASK};
      UPD_STEP:  sr_nxt = {bank_step_nxt, sr_q[FLAG_W-1:0]};
      UPD_FLAGS: sr_nxt = {sr_q[SR_W-1:FLAG_W], flag_in & LIVE_MASK};
      default:   sr_nxt = sr_q;
    endcase
  end

  assign load_en    = (kind != UPD_NONE);
  assign step_taken = (kind == UPD_STEP);

endmodule

// File: rtl/status_bank_reg.sv
module status_bank_reg #(
  parameter int BANK_W     = 8,
  parameter int FLAG_W     = 8,
  parameter int LIVE_FLAGS = 5,
  parameter int ADDR_W     = 16,
  localparam int SR_W      = BANK_W + FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_inc,
  input  logic              bank_dec,
  input  logic              sr_wr_en,
  input  logic [SR_W-1:0]   sr_wr_data,
  input  logic              flag_upd_en,
  input  logic [FLAG_W-1:0] flag_upd_in,
  input  logic [ADDR_W-1:0] pc_in,
  output logic [SR_W-1:0]   sr_out,
  output logic [BANK_W-1:0] bank_sel,
  output logic              fetch_return,
  output logic [ADDR_W-1:0] fetch_addr
);

  logic              rst_sync_n;
  logic [SR_W-1:0]   sr_q;
  logic [SR_W-1:0]   sr_nxt;
  logic [BANK_W-1:0] bank_sel_q;
  logic              fr_q;
  logic              fr_nxt;
  logic [ADDR_W-1:0] faddr_q;
  logic [ADDR_W-1:0] faddr_nxt;
  logic              sr_load;
  logic              step_req;
  logic              step_taken;
  logic [BANK_W-1:0] bank_step_nxt;

  sr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sr_bank_step #(.BANK_W(BANK_W)) u_step (
    .bank_q   (sr_q[SR_W-1:FLAG_W]),
    .inc      (bank_inc),
    .dec      (bank_dec),
    .step_req (step_req),
    .bank_nxt (bank_step_nxt)
  );

  sr_next_sel #(
    .BANK_W     (BANK_W),
    .FLAG_W     (FLAG_W),
    .LIVE_FLAGS (LIVE_FLAGS)
  ) u_sel (
    .sr_q          (sr_q),
    .wr_en         (sr_wr_en),
    .wr_data       (sr_wr_data),
    .step_req      (step_req),
    .bank_step_nxt (bank_step_nxt),
    .flag_en       (flag_upd_en),
    .flag_in       (flag_upd_in),
    .sr_nxt        (sr_nxt),
    .load_en       (sr_load),
    .step_taken    (step_taken)
  );

  // Fetch-return sequencing: one pulse after a taken step, address captured then.
  always_comb begin
    fr_nxt    = step_taken;
    faddr_nxt = step_taken ? pc_in : faddr_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sr_q       <= '0;
      bank_sel_q <= '0;
    end else if (sr_load) begin
      sr_q       <= sr_nxt;
      bank_sel_q <= sr_nxt[SR_W-1:FLAG_W];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fr_q    <= 1'b0;
      faddr_q <= '0;
    end else begin
      fr_q    <= fr_nxt;
      faddr_q <= faddr_nxt;
    end
  end

  assign sr_out       = sr_q;
  assign bank_sel     = bank_sel_q;
  assign fetch_return = fr_q;
  assign fetch_addr   = faddr_q;

endmodule

// File: rtl/sr_checker.sv
module sr_checker #(
  parameter int BANK_W     = 8,
  parameter int FLAG_W     = 8,
  parameter int LIVE_FLAGS = 5,
  parameter int ADDR_W     = 16,
  localparam int SR_W      = BANK_W + FLAG_W
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              bank_inc,
  input logic              bank_dec,
  input logic              sr_wr_en,
  input logic [SR_W-1:0]   sr_wr_data,
  input logic              flag_upd_en,
  input logic [ADDR_W-1:0] pc_in,
  input logic [SR_W-1:0]   sr_out,
  input logic [BANK_W-1:0] bank_sel,
  input logic              fetch_return,
  input logic [ADDR_W-1:0] fetch_addr
);

  localparam logic [BANK_W-1:0] ONE = BANK_W'(1);
  localparam logic [FLAG_W-1:0] LIVE_MASK =
    {{(FLAG_W-LIVE_FLAGS){1'b0}}, {LIVE_FLAGS{1'b1}}};

  logic [BANK_W-1:0] bank_now;
  logic [FLAG_W-1:0] flags_now;
  logic              step_in;

  assign bank_now  = sr_out[SR_W-1:FLAG_W];
  assign flags_now = sr_out[FLAG_W-1:0];
  assign step_in   = (bank_inc | bank_dec) & ~sr_wr_en;

  // R2
  inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bank_inc && !sr_wr_en) |=> (bank_now == $past(bank_now) + ONE));

  // R3
  dec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bank_dec && !bank_inc && !sr_wr_en) |=> (bank_now == $past(bank_now) - ONE));

  // R4
  step_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    step_in |=> (flags_now == $past(flags_now)));

  // R5
  fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    step_in |=> (fetch_return && fetch_addr == $past(pc_in)));

  // R5
  fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !step_in |=> (!fetch_return && $stable(fetch_addr)));

  // R6
  general_write_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    sr_wr_en |=> (bank_now == $past(sr_wr_data[SR_W-1:FLAG_W]) &&
                  flags_now == ($past(sr_wr_data[FLAG_W-1:0]) & LIVE_MASK)));

  // R7
  flag_keeps_bank_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flag_upd_en && !bank_inc && !bank_dec && !sr_wr_en) |=> $stable(bank_now));

  // R8
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((flags_now & ~LIVE_MASK) == '0));

  // R10
  bank_sel_copy_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bank_sel == bank_now));

endmodule

bind status_bank_reg sr_checker #(
  .BANK_W     (BANK_W),
  .FLAG_W     (FLAG_W),
  .LIVE_FLAGS (LIVE_FLAGS),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_int_n    (rst_sync_n),
  .bank_inc     (bank_inc),
  .bank_dec     (bank_dec),
  .sr_wr_en     (sr_wr_en),
  .sr_wr_data   (sr_wr_data),
  .flag_upd_en  (flag_upd_en),
  .pc_in        (pc_in),
  .sr_out       (sr_out),
  .bank_sel     (bank_sel),
  .fetch_return (fetch_return),
  .fetch_addr   (fetch_addr)
);

// File: tb/sim_status_bank_reg.sv
`timescale 1ns/1ps
module sim_status_bank_reg;

  logic        clk;
  logic        rst_n;
  logic        bank_inc;
  logic        bank_dec;
  logic        sr_wr_en;
  logic [15:0] sr_wr_data;
  logic        flag_upd_en;
  logic [7:0]  flag_upd_in;
  logic [15:0] pc_in;
  logic [15:0] sr_out;
  logic [7:0]  bank_sel;
  logic        fetch_return;
  logic [15:0] fetch_addr;

  int vectors;
  int miscompares;
  bit done;

  // Behavioural reference state
  int m_bank;
  int m_flags;
  int m_fr;
  int m_faddr;

  status_bank_reg u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .bank_inc     (bank_inc),
    .bank_dec     (bank_dec),
    .sr_wr_en     (sr_wr_en),
    .sr_wr_data   (sr_wr_data),
    .flag_upd_en  (flag_upd_en),
    .flag_upd_in  (flag_upd_in),
    .pc_in        (pc_in),
    .sr_out       (sr_out),
    .bank_sel     (bank_sel),
    .fetch_return (fetch_return),
    .fetch_addr   (fetch_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic compare(input string tag);
    int exp_sr;
    exp_sr = (m_bank << 8) | m_flags;
    vectors++;
    if (int'(sr_out) != exp_sr || int'(bank_sel) != m_bank ||
        int'(fetch_return) != m_fr || int'(fetch_addr) != m_faddr) begin
      miscompares++;
      $display("FAIL %s: actual sr=%h bank=%h fr=%0d fa=%h expected sr=%h bank=%h fr=%0d fa=%h",
               tag, sr_out, bank_sel, fetch_return, fetch_addr,
               exp_sr[15:0], m_bank[7:0], m_fr, m_faddr[15:0]);
    end
  endtask

  // Drive one cycle of stimulus, advance the model, compare after the edge.
  task automatic apply(input bit inc, input bit dec, input bit wr, input int wd,
                       input bit fe, input int fi, input int pc, input string tag);
    bank_inc    = inc;
    bank_dec    = dec;
    sr_wr_en    = wr;
    sr_wr_data  = wd[15:0];
    flag_upd_en = fe;
    flag_upd_in = fi[7:0];
    pc_in       = pc[15:0];
    @(posedge clk);
    m_fr = 0;
    if (wr) begin
      m_bank  = (wd >> 8) & 255;
      m_flags = wd & 31;
    end else if (inc || dec) begin
      m_bank  = inc ? (m_bank + 1) % 256 : (m_bank + 255) % 256;
      m_fr    = 1;
      m_faddr = pc & 16'hFFFF;
    end else if (fe) begin
      m_flags = fi & 31;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    apply(0, 0, 0, 0, 0, 0, 16'h1234, tag);
  endtask

  initial begin
    int lfsr;
    vectors = 0; miscompares = 0; done = 0;
    m_bank = 0; m_flags = 0; m_fr = 0; m_faddr = 0;
    rst_n = 1'b0;
    bank_inc = 0; bank_dec = 0; sr_wr_en = 0; sr_wr_data = '0;
    flag_upd_en = 0; flag_upd_in = '0; pc_in = '0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    repeat (3) idle("R1");

    // Plain steps up and down
    apply(1, 0, 0, 0, 0, 0, 16'h0040, "R2");
    apply(1, 0, 0, 0, 0, 0, 16'h0042, "R2");
    idle("R5");
    apply(0, 1, 0, 0, 0, 0, 16'h0050, "R3");
    idle("R5");

    // Wrap edges
    apply(0, 0, 1, 16'hFF00, 0, 0, 0, "R6");
    apply(1, 0, 0, 0, 0, 0, 16'h0100, "R2");
    apply(0, 1, 0, 0, 0, 0, 16'h0102, "R3");
    apply(1, 0, 0, 0, 0, 0, 16'h0104, "R2");

    // Flag preservation for every live flag pattern across both steps and wraps
    for (int f = 0; f < 32; f++) begin
      apply(0, 0, 1, (((f * 37) & 255) << 8) | f, 0, 0, 0, "R6");
      apply(1, 0, 0, 0, 0, 0, 16'h2000 + f, "R4");
      apply(0, 1, 0, 0, 0, 0, 16'h3000 + f, "R4");
      apply(0, 1, 0, 0, 0, 0, 16'h3100 + f, "R4");
    end
    apply(0, 0, 1, 16'h001F, 0, 0, 0, "R6");
    apply(0, 1, 0, 0, 0, 0, 16'h0AAA, "R4");
    apply(1, 0, 0, 0, 0, 0, 16'h0BBB, "R4");

    // General write: old value 0x0005 plus 0x0100
    apply(0, 0, 1, 16'h0005, 0, 0, 0, "R6");
    apply(0, 0, 1, 16'h0005 + 16'h0100, 0, 0, 0, "R6");
    idle("R6");

    // Flag update alone, bank untouched
    apply(0, 0, 0, 0, 1, 8'h0A, 0, "R7");
    apply(0, 0, 0, 0, 1, 8'h15, 0, "R7");

    // Unused flag bits
    apply(0, 0, 1, 16'hFFFF, 0, 0, 0, "R8");
    apply(0, 0, 0, 0, 1, 8'hE0, 0, "R8");

    // Collisions
    apply(0, 0, 1, 16'h0713, 0, 0, 0, "R6");
    apply(1, 0, 0, 0, 1, 8'h0C, 16'h0777, "R9");
    apply(0, 1, 0, 0, 1, 8'h1F, 16'h0778, "R9");
    apply(1, 0, 1, 16'h4402, 1, 8'h11, 16'h0779, "R9");
    apply(1, 1, 0, 0, 0, 0, 16'h077A, "R9");
    apply(1, 1, 1, 16'h0909, 1, 8'h03, 16'h077B, "R9");
    idle("R10");

    // Mixed random sequence
    lfsr = 32'h1ACE;
    for (int n = 0; n < 400; n++) begin
      lfsr = (lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1);
      lfsr = lfsr & 16'hFFFF;
      apply(lfsr[0], lfsr[1], (lfsr[4:2] == 3'b000), lfsr ^ 16'h5A5A,
            lfsr[5], lfsr >> 7, lfsr ^ n, "R10");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule